// File: doc/BRIEF.md
# Flash Program and Erase Bus Sequencer

This block sits on the host side of an asynchronous, byte-wide NOR flash bus. It accepts one command at a time on a valid/ready handshake. A command programs a single byte, erases a set of sectors, or erases the whole chip. For each command the block drives chip enable, write enable, address and write data through the fixed unlock and command write cycles that the flash expects.

After the last write, the block keeps output enable low on the polled address and watches bit 7 of the read data. While the flash is still busy, that bit returns the complement of the expected value. The block then returns one pulse: `done_o` when the bit matches, or `timeout_o` when the sample budget set with the request runs out.

Every strobe width, hold time and bus-release time is a nanosecond parameter. Each one is rounded up to whole cycles of the `CLK_NS` clock period.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `req_ready` is 1, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are 1, `flash_dq_oe` is 0, and `done_o` and `timeout_o` are 0.
- R2: A byte program (op code 0) issues exactly four write cycles: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address. Chip enable is low whenever write enable is low.
- R3: A sector erase (op code 1) issues AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. It then writes 30h once to each sector whose mask bit is set, in ascending sector order. Sector i is addressed at i shifted left by `SECT_SHIFT`.
- R4: A chip erase (op code 2) issues the same five lead-in writes as R3, followed by a single 10h@5555h.
- R5: Each write-enable low pulse lasts at least max(ceil(TWP_NS/CLK_NS), ceil(TAH_NS/CLK_NS)) cycles. Address and data stay constant throughout the pulse, and the data bus is driven when write enable rises.
- R6: Between two write-enable pulses of one command, write enable stays high for at least ceil(TWPH_NS/CLK_NS) cycles.
- R7: After the last write, output enable goes low on the poll address: the request address for a program or a chip erase, and the highest selected sector for a sector erase. The first sample of read bit 7 is taken after ceil(TOE_NS/CLK_NS) cycles. The command ends with `done_o` at the first sample equal to the expected bit, which is data bit 7 for a program and 1 for an erase.
- R8: If `req_poll_limit` samples (at least one) all miss, the command ends with `timeout_o` instead of `done_o`, with output enable low for ceil(TOE_NS/CLK_NS) plus the limit cycles. The two pulses never occur together.
- R9: `req_ready` drops in the cycle after a request is accepted. It stays low until the single one-cycle result pulse, and requests offered in between are ignored.
- R10: A sector erase with an all-zero mask, or the reserved op code 3, creates no bus activity. It produces `done_o` in the second cycle after acceptance.
- R11: Output enable is never low while the block drives data or while write enable is low. At least ceil(TDF_NS/CLK_NS) cycles pass after output enable rises before the result pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Block idle and able to take a command |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | ADDR_W | Program address, or poll address for chip erase |
| req_data | input | DATA_W | Byte to program |
| req_sect_mask | input | NUM_SECT | One bit per sector to erase |
| req_poll_limit | input | POLL_W | Maximum number of status samples |
| done_o | output | 1 | One-cycle pulse, command finished |
| timeout_o | output | 1 | One-cycle pulse, polling budget exhausted |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_addr | output | ADDR_W | Flash address |
| flash_dq_o | output | DATA_W | Write data |
| flash_dq_oe | output | 1 | Write data driver enable |
| flash_dq7_i | input | 1 | Read data bit 7 from the flash |

## Verification
The embedded properties assume that reset is applied synchronously for several cycles. They also assume that the flash answers only through `flash_dq7_i`, which the bench changes only at falling clock edges. They do not assume any limit on how long `req_valid` stays high.

The bench raises `req_valid` only when `req_ready` is known to be high. In one scenario it deliberately holds `req_valid` high with altered fields throughout a busy command, and it drops `req_valid` in the same cycle as the result pulse so that no second command is accepted.

The bench's flash model keeps bit 7 wrong for a chosen number of samples. It picks counts both below and above the request's sample limit, so both the `done_o` and the `timeout_o` outcomes are reached.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [1:0] {
      FCS_PROG = 2'd0,
      FCS_SECT = 2'd1,
      FCS_CHIP = 2'd2,
      FCS_RSVD = 2'd3
   } fcs_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SKIP,
      S_ISSUE,
      S_WAIT,
      S_POLL,
      S_RECOV
   } fcs_state_e;

   // unlock and command words
   localparam logic [15:0] FCS_ADR_A = 16'h5555;
   localparam logic [15:0] FCS_ADR_B = 16'h2AAA;
   localparam logic [7:0]  FCS_D_AA  = 8'hAA;
   localparam logic [7:0]  FCS_D_55  = 8'h55;
   localparam logic [7:0]  FCS_D_PGM = 8'hA0;
   localparam logic [7:0]  FCS_D_ERS = 8'h80;
   localparam logic [7:0]  FCS_D_SEC = 8'h30;
   localparam logic [7:0]  FCS_D_CHP = 8'h10;

   // index of the step that carries the per-sector / chip-erase command
   localparam logic [2:0]  FCS_STEP_FINAL = 3'd5;
   localparam logic [2:0]  FCS_STEP_PDATA = 3'd3;

   // nanoseconds to whole cycles, never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/fcs_sect_pick.sv
module fcs_sect_pick #(
   parameter int NUM_SECT = 8,
   localparam int IW = $clog2(NUM_SECT)
) (
   input  logic [NUM_SECT-1:0] mask,
   output logic [IW-1:0]       idx,
   output logic [NUM_SECT-1:0] onehot
);

   if (NUM_SECT < 2) begin : g_bad_count
      $error("fcs_sect_pick: NUM_SECT must be at least 2");
   end

   // lowest selected sector wins, so sectors go out in ascending order
   always_comb begin
      idx = '0;
      for (int i = NUM_SECT - 1; i >= 0; i--) begin
         if (mask[i]) idx = IW'(i);
      end
   end

   assign onehot = mask & (~mask + NUM_SECT'(1));

endmodule

// File: rtl/fcs_step_gen.sv
module fcs_step_gen
   import fcs_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  fcs_op_e           op,
   input  logic [2:0]        step,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [DATA_W-1:0] tgt_data,
   input  logic [ADDR_W-1:0] sect_addr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data
);

   localparam logic [ADDR_W-1:0] A_A = ADDR_W'(FCS_ADR_A);
   localparam logic [ADDR_W-1:0] A_B = ADDR_W'(FCS_ADR_B);

   always_comb begin
      cmd_addr = A_A;
      cmd_data = DATA_W'(FCS_D_AA);
      if (op == FCS_PROG) begin
         case (step)
            3'd0: begin cmd_addr = A_A; cmd_data = DATA_W'(FCS_D_AA); end
            3'd1: begin cmd_addr = A_B; cmd_data = DATA_W'(FCS_D_55); end
            3'd2: begin cmd_addr = A_A; cmd_data = DATA_W'(FCS_D_PGM); end
            default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
         endcase
      end else begin
         case (step)
            3'd0: begin cmd_addr = A_A; cmd_data = DATA_W'(FCS_D_AA); end
            3'd1: begin cmd_addr = A_B; cmd_data = DATA_W'(FCS_D_55); end
            3'd2: begin cmd_addr = A_A; cmd_data = DATA_W'(FCS_D_ERS); end
            3'd3: begin cmd_addr = A_A; cmd_data = DATA_W'(FCS_D_AA); end
            3'd4: begin cmd_addr = A_B; cmd_data = DATA_W'(FCS_D_55); end
            default: begin
               if (op == FCS_SECT) begin
                  cmd_addr = sect_addr; cmd_data = DATA_W'(FCS_D_SEC);
               end else begin
                  cmd_addr = A_A;       cmd_data = DATA_W'(FCS_D_CHP);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/fcs_wr_cycle.sv
module fcs_wr_cycle #(
   parameter int LOW_C  = 5,
   parameter int HIGH_C = 2,
   localparam int MAXC  = (LOW_C > HIGH_C) ? LOW_C : HIGH_C,
   localparam int CW    = $clog2(MAXC + 1) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic we_n,
   output logic fin
);

   if (LOW_C < 1 || HIGH_C < 1 || LOW_C > 200) begin : g_bad_cyc
      $error("fcs_wr_cycle: pulse lengths out of range");
   end

   typedef enum logic [1:0] {W_IDLE, W_SETUP, W_LOW, W_HIGH} wst_e;

   wst_e          st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= W_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            W_IDLE:  if (start) st_q <= W_SETUP;
            W_SETUP: begin
               st_q  <= W_LOW;
               cnt_q <= '0;
            end
            W_LOW: begin
               if (cnt_q == CW'(LOW_C - 1)) begin
                  st_q  <= W_HIGH;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: begin
               if (cnt_q == CW'(HIGH_C - 1)) st_q <= W_IDLE;
               else                           cnt_q <= cnt_q + CW'(1);
            end
         endcase
      end
   end

   assign we_n = (st_q != W_LOW);
   assign fin  = (st_q == W_HIGH) && (cnt_q == CW'(HIGH_C - 1));

   // ---- checks ----
   logic [7:0] lo_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      lo_run_q <= '0;
      else if (!we_n)  lo_run_q <= lo_run_q + 8'd1;
      else             lo_run_q <= '0;
   end

   assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (lo_run_q >= 8'(LOW_C)));

   assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (st_q == W_IDLE));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int CLK_NS     = 10,
   parameter int ADDR_W     = 19,
   parameter int DATA_W     = 8,
   parameter int NUM_SECT   = 8,
   parameter int SECT_SHIFT = 16,
   parameter int POLL_W     = 16,
   parameter int TWP_NS     = 40,
   parameter int TWPH_NS    = 20,
   parameter int TAH_NS     = 45,
   parameter int TDS_NS     = 40,
   parameter int TOE_NS     = 30,
   parameter int TDF_NS     = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   input  logic [NUM_SECT-1:0] req_sect_mask,
   input  logic [POLL_W-1:0]   req_poll_limit,
   output logic                done_o,
   output logic                timeout_o,
   output logic                flash_ce_n,
   output logic                flash_we_n,
   output logic                flash_oe_n,
   output logic [ADDR_W-1:0]   flash_addr,
   output logic [DATA_W-1:0]   flash_dq_o,
   output logic                flash_dq_oe,
   input  logic                flash_dq7_i
);

   localparam int WP_C   = ns_to_cyc(TWP_NS, CLK_NS);
   localparam int AH_C   = ns_to_cyc(TAH_NS, CLK_NS);
   localparam int DS_C   = ns_to_cyc(TDS_NS, CLK_NS);
   localparam int LOW0_C = (WP_C > AH_C) ? WP_C : AH_C;
   // data is driven one setup cycle before the pulse, so DS_C-1 low cycles suffice
   localparam int LOW_C  = (LOW0_C > DS_C - 1) ? LOW0_C : DS_C - 1;
   localparam int HIGH_C = ns_to_cyc(TWPH_NS, CLK_NS);
   localparam int TOE_C  = ns_to_cyc(TOE_NS, CLK_NS);
   localparam int DF_C   = ns_to_cyc(TDF_NS, CLK_NS);
   localparam int IW     = $clog2(NUM_SECT);
   localparam int CW     = $clog2(((TOE_C > DF_C) ? TOE_C : DF_C) + 1) + 1;

   if (CLK_NS < 1) begin : g_bad_clk
      $error("flash_cmd_seq: CLK_NS must be positive");
   end
   if (ADDR_W < 16 || DATA_W < 8) begin : g_bad_width
      $error("flash_cmd_seq: bus too narrow for the command words");
   end
   if (SECT_SHIFT + IW > ADDR_W) begin : g_bad_sect
      $error("flash_cmd_seq: sectors do not fit in the address range");
   end
   if (POLL_W < 1 || POLL_W > 32) begin : g_bad_poll
      $error("flash_cmd_seq: POLL_W out of range");
   end

   fcs_state_e          state_q;
   fcs_op_e             op_q;
   logic [ADDR_W-1:0]   addr_q, poll_addr_q, bus_addr_q, sect_addr, cmd_addr;
   logic [DATA_W-1:0]   data_q, bus_data_q, cmd_data;
   logic [NUM_SECT-1:0] mask_q, pick_1h;
   logic [IW-1:0]       pick_idx;
   logic [POLL_W-1:0]   limit_q, pcnt_q;
   logic [2:0]          step_q;
   logic [CW-1:0]       tcnt_q;
   logic                drive_q, exp7_q, ok_q, done_q, tout_q;
   logic                wr_start, wr_fin, wr_we_n, final_step;

   fcs_sect_pick #(.NUM_SECT(NUM_SECT)) u_pick (
      .mask   (mask_q),
      .idx    (pick_idx),
      .onehot (pick_1h)
   );

   always_comb begin
      sect_addr = '0;
      sect_addr[SECT_SHIFT +: IW] = pick_idx;
   end

   fcs_step_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step (
      .op        (op_q),
      .step      (step_q),
      .tgt_addr  (addr_q),
      .tgt_data  (data_q),
      .sect_addr (sect_addr),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data)
   );

   assign wr_start = (state_q == S_ISSUE);

   fcs_wr_cycle #(.LOW_C(LOW_C), .HIGH_C(HIGH_C)) u_wr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_start),
      .we_n  (wr_we_n),
      .fin   (wr_fin)
   );

   always_comb begin
      case (op_q)
         FCS_PROG: final_step = (step_q == FCS_STEP_PDATA);
         FCS_SECT: final_step = (step_q == FCS_STEP_FINAL) && (mask_q == '0);
         default:  final_step = (step_q == FCS_STEP_FINAL);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         op_q        <= FCS_PROG;
         addr_q      <= '0;
         data_q      <= '0;
         mask_q      <= '0;
         limit_q     <= '0;
         poll_addr_q <= '0;
         bus_addr_q  <= '0;
         bus_data_q  <= '0;
         step_q      <= '0;
         tcnt_q      <= '0;
         pcnt_q      <= '0;
         drive_q     <= 1'b0;
         exp7_q      <= 1'b1;
         ok_q        <= 1'b0;
         done_q      <= 1'b0;
         tout_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         tout_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q        <= fcs_op_e'(req_op);
                  addr_q      <= req_addr;
                  data_q      <= req_data;
                  mask_q      <= req_sect_mask;
                  limit_q     <= req_poll_limit;
                  poll_addr_q <= req_addr;
                  step_q      <= '0;
                  exp7_q      <= (fcs_op_e'(req_op) == FCS_PROG) ? req_data[7] : 1'b1;
                  if (fcs_op_e'(req_op) == FCS_RSVD ||
                      (fcs_op_e'(req_op) == FCS_SECT && req_sect_mask == '0))
                     state_q <= S_SKIP;
                  else
                     state_q <= S_ISSUE;
               end
            end
            S_SKIP: begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            S_ISSUE: begin
               bus_addr_q <= cmd_addr;
               bus_data_q <= cmd_data;
               drive_q    <= 1'b1;
               if (op_q == FCS_SECT && step_q == FCS_STEP_FINAL) begin
                  mask_q      <= mask_q & ~pick_1h;
                  poll_addr_q <= sect_addr;
               end
               state_q <= S_WAIT;
            end
            S_WAIT: begin
               if (wr_fin) begin
                  if (final_step) begin
                     bus_addr_q <= poll_addr_q;
                     drive_q    <= 1'b0;
                     tcnt_q     <= '0;
                     pcnt_q     <= '0;
                     state_q    <= S_POLL;
                  end else begin
                     if (step_q != FCS_STEP_FINAL) step_q <= step_q + 3'd1;
                     state_q <= S_ISSUE;
                  end
               end
            end
            S_POLL: begin
               if (tcnt_q != CW'(TOE_C)) begin
                  tcnt_q <= tcnt_q + CW'(1);
               end else if (flash_dq7_i == exp7_q) begin
                  ok_q    <= 1'b1;
                  tcnt_q  <= '0;
                  state_q <= S_RECOV;
               end else if (limit_q <= POLL_W'(1) || pcnt_q == limit_q - POLL_W'(1)) begin
                  ok_q    <= 1'b0;
                  tcnt_q  <= '0;
                  state_q <= S_RECOV;
               end else begin
                  pcnt_q <= pcnt_q + POLL_W'(1);
               end
            end
            default: begin
               if (tcnt_q == CW'(DF_C - 1)) begin
                  done_q  <= ok_q;
                  tout_q  <= !ok_q;
                  state_q <= S_IDLE;
               end else begin
                  tcnt_q <= tcnt_q + CW'(1);
               end
            end
         endcase
      end
   end

   assign req_ready   = (state_q == S_IDLE);
   assign done_o      = done_q;
   assign timeout_o   = tout_q;
   assign flash_ce_n  = !(state_q == S_ISSUE || state_q == S_WAIT || state_q == S_POLL);
   assign flash_oe_n  = (state_q != S_POLL);
   assign flash_we_n  = wr_we_n;
   assign flash_addr  = bus_addr_q;
   assign flash_dq_o  = bus_data_q;
   assign flash_dq_oe = drive_q;

   // ---- checks ----
   assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_dq_oe && !flash_oe_n));

   assert_oe_we_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!flash_oe_n && !flash_we_n));

   assert_ce_with_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> !flash_ce_n);

   assert_bus_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_o)));

   assert_drive_at_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> flash_dq_oe);

   assert_one_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && timeout_o));

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || timeout_o) |=> !(done_o || timeout_o));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

   localparam int CLK_NS = 10;
   localparam int AW = 19;
   localparam int DW = 8;
   localparam int NS = 8;
   localparam int SSH = 16;
   localparam int PW = 16;
   localparam int EXP_LOW  = ((45 + CLK_NS - 1) / CLK_NS > (40 + CLK_NS - 1) / CLK_NS) ?
                             (45 + CLK_NS - 1) / CLK_NS : (40 + CLK_NS - 1) / CLK_NS;
   localparam int EXP_HIGH = (20 + CLK_NS - 1) / CLK_NS;
   localparam int EXP_TOE  = (30 + CLK_NS - 1) / CLK_NS;
   localparam int EXP_DF   = (20 + CLK_NS - 1) / CLK_NS;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          req_valid, req_ready;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic [NS-1:0] req_sect_mask;
   logic [PW-1:0] req_poll_limit;
   logic          done_o, timeout_o;
   logic          flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe;
   logic [AW-1:0] flash_addr;
   logic [DW-1:0] flash_dq_o;
   logic          flash_dq7_i;

   flash_cmd_seq #(.CLK_NS(CLK_NS), .ADDR_W(AW), .DATA_W(DW), .NUM_SECT(NS),
                   .SECT_SHIFT(SSH), .POLL_W(PW)) u_flash_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .req_sect_mask(req_sect_mask), .req_poll_limit(req_poll_limit),
      .done_o(done_o), .timeout_o(timeout_o), .flash_ce_n(flash_ce_n),
      .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n), .flash_addr(flash_addr),
      .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe), .flash_dq7_i(flash_dq7_i));

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- bus monitor and flash status model ----------------
   logic [AW-1:0] wa [0:15];
   logic [DW-1:0] wd [0:15];
   int  wn, min_lo, min_hi, lo_run, hi_run, oe_run, oe_len, gap, ce_lo, drive_bad;
   bit  gap_on, prev_we;
   logic [AW-1:0] poll_a;
   int  busy_thr;
   bit  exp7;

   task automatic mon_clear();
      wn = 0; min_lo = 999; min_hi = 999; lo_run = 0; hi_run = 0;
      oe_len = 0; gap = 0; gap_on = 0; ce_lo = 0; drive_bad = 0; poll_a = '0;
   endtask

   initial begin
      mon_clear();
      oe_run = 0; prev_we = 1; busy_thr = 0; exp7 = 1; flash_dq7_i = 1'b0;
   end

   always @(negedge clk) begin
      if (!flash_we_n) begin
         if (prev_we && wn > 0 && hi_run < min_hi) min_hi = hi_run;
         lo_run++;
      end else begin
         if (!prev_we) begin
            if (wn < 16) begin wa[wn] = flash_addr; wd[wn] = flash_dq_o; end
            wn++;
            if (lo_run < min_lo) min_lo = lo_run;
            if (!flash_dq_oe) drive_bad++;
            hi_run = 1;
         end else begin
            hi_run++;
         end
         lo_run = 0;
      end
      prev_we = flash_we_n;
      if (!flash_ce_n) ce_lo++;
      if (!flash_oe_n) begin
         if (oe_run == 0) poll_a = flash_addr;
         oe_run++;
         flash_dq7_i = (oe_run >= busy_thr + EXP_TOE + 1) ? exp7 : !exp7;
      end else begin
         if (oe_run > 0) begin oe_len = oe_run; gap_on = 1; gap = 0; end
         oe_run = 0;
         flash_dq7_i = 1'b0;
         if (done_o || timeout_o) gap_on = 0;
         else if (gap_on) gap++;
      end
   end

   // ---------------- request driver ----------------
   bit got_done, got_to;

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [NS-1:0] m, input int lim, input int busy,
                         input bit hold, input string req);
      int n;
      @(negedge clk);
      mon_clear();
      busy_thr = busy;
      exp7 = (op == 2'd0) ? d[7] : 1'b1;
      req_op = op; req_addr = a; req_data = d; req_sect_mask = m;
      req_poll_limit = PW'(lim); req_valid = 1'b1;
      check(req_ready == 1'b1, req, "ready before request", req_ready, 1);
      @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
      if (hold) begin
         req_op = 2'd2; req_addr = '1; req_data = 8'hFF;
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (!(done_o || timeout_o) && n < 5000) begin
         if (req_ready) check(0, "R9", "ready high while busy", 1, 0);
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      got_done = done_o; got_to = timeout_o;
      check(req_ready == 1'b1, "R9", "ready with result pulse", req_ready, 1);
      @(negedge clk);
      check(!done_o && !timeout_o, "R9", "result pulse one cycle", {done_o, timeout_o}, 0);
      check(req_ready == 1'b1, "R9", "idle after command", req_ready, 1);
   endtask

   task automatic check_writes(input string req, input int cnt,
                               input logic [AW-1:0] ea [0:15], input logic [7:0] ed [0:15]);
      check(wn == cnt, req, "write count", wn, cnt);
      for (int i = 0; i < cnt && i < wn; i++) begin
         check(wa[i] == ea[i], req, $sformatf("write %0d address", i), wa[i], ea[i]);
         check(wd[i] == ed[i], req, $sformatf("write %0d data", i), wd[i], ed[i]);
      end
      check(min_lo >= EXP_LOW, "R5", "shortest write-enable low", min_lo, EXP_LOW);
      check(drive_bad == 0, "R5", "data driven at strobe rise", drive_bad, 0);
      if (cnt > 1) check(min_hi >= EXP_HIGH, "R6", "shortest write-enable high", min_hi, EXP_HIGH);
   endtask

   task automatic check_poll(input logic [AW-1:0] pa, input int samples);
      check(poll_a == pa, "R7", "poll address", poll_a, pa);
      check(oe_len == EXP_TOE + samples, "R7", "output-enable low cycles", oe_len, EXP_TOE + samples);
      check(gap >= EXP_DF, "R11", "release cycles before result", gap, EXP_DF);
   endtask

   logic [AW-1:0] ea [0:15];
   logic [7:0]    ed [0:15];

   task automatic lead_in(input bit erase);
      ea[0] = AW'(16'h5555); ed[0] = 8'hAA;
      ea[1] = AW'(16'h2AAA); ed[1] = 8'h55;
      ea[2] = AW'(16'h5555); ed[2] = erase ? 8'h80 : 8'hA0;
      ea[3] = AW'(16'h5555); ed[3] = 8'hAA;
      ea[4] = AW'(16'h2AAA); ed[4] = 8'h55;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      check({flash_ce_n, flash_we_n, flash_oe_n} == 3'b111, "R1", "strobes idle",
            {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
      check(flash_dq_oe == 1'b0, "R1", "data driver off", flash_dq_oe, 0);
      check(!done_o && !timeout_o, "R1", "no result pulse", {done_o, timeout_o}, 0);
   endtask

   task automatic t_prog(input logic [AW-1:0] a, input logic [7:0] d, input int busy);
      run_op(2'd0, a, d, '0, 100, busy, 0, "R2");
      lead_in(0);
      ea[3] = a; ed[3] = d;
      check_writes("R2", 4, ea, ed);
      check(got_done && !got_to, "R7", "program completes", {got_done, got_to}, 2'b10);
      check_poll(a, busy + 1);
   endtask

   task automatic t_sect();
      run_op(2'd1, '0, 8'h00, 8'b1010_0100, 100, 3, 0, "R3");
      lead_in(1);
      ea[5] = AW'(32'h20000); ed[5] = 8'h30;
      ea[6] = AW'(32'h50000); ed[6] = 8'h30;
      ea[7] = AW'(32'h70000); ed[7] = 8'h30;
      check_writes("R3", 8, ea, ed);
      check(got_done && !got_to, "R7", "sector erase completes", {got_done, got_to}, 2'b10);
      check_poll(AW'(32'h70000), 4);
   endtask

   task automatic t_chip();
      run_op(2'd2, AW'(32'h00123), 8'h00, '0, 50, 2, 0, "R4");
      lead_in(1);
      ea[5] = AW'(16'h5555); ed[5] = 8'h10;
      check_writes("R4", 6, ea, ed);
      check(got_done && !got_to, "R7", "chip erase completes", {got_done, got_to}, 2'b10);
      check_poll(AW'(32'h00123), 3);
   endtask

   task automatic t_timeout();
      run_op(2'd0, AW'(32'h40001), 8'h9C, '0, 6, 1000, 0, "R8");
      check(!got_done && got_to, "R8", "timeout reported", {got_done, got_to}, 2'b01);
      check_poll(AW'(32'h40001), 6);
   endtask

   task automatic t_skip(input logic [1:0] op);
      int n;
      @(negedge clk);
      mon_clear();
      req_op = op; req_sect_mask = '0; req_addr = '0; req_data = '0;
      req_poll_limit = PW'(4); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!done_o && n < 10) begin @(negedge clk); n++; end
      check(done_o == 1'b1 && n == 2, "R10", "done two cycles after accept", n, 2);
      check(ce_lo == 0 && wn == 0, "R10", "no bus activity", ce_lo + wn, 0);
      @(negedge clk);
   endtask

   task automatic t_hold();
      run_op(2'd0, AW'(32'h00777), 8'h5A, '0, 20, 0, 1, "R9");
      lead_in(0);
      ea[3] = AW'(32'h00777); ed[3] = 8'h5A;
      check_writes("R9", 4, ea, ed);
      check(got_done, "R9", "held request served once", got_done, 1);
      repeat (3) @(negedge clk);
      check(wn == 4, "R9", "no second command started", wn, 4);
   endtask

   // watchdog
   initial begin
      #(CLK_NS * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
      req_sect_mask = '0; req_poll_limit = '0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog(AW'(32'h1234A), 8'hC3, 5);
      t_prog(AW'(32'h00042), 8'h35, 0);
      t_sect();
      t_chip();
      t_timeout();
      t_skip(2'd1);
      t_skip(2'd3);
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule